// File: doc/BRIEF.md
# Write-Protected Seconds Real-Time Clock

This block keeps time as a 32-bit count of seconds. An external one-pulse-per-second strobe advances it. A host reaches the count through a small synchronous register port with 16-bit data. The count is split into a low half and a high half, and a third register holds a single write-enable bit.

The count is protected against stray writes. The host must first set the enable bit. Only then do writes to either half take effect. A write to the high half while the window is open also closes the window, so the usual sequence is: enable, low half, high half.

A host write that lands in the same cycle as a tick wins, and that tick is lost. Read data appears one cycle after the read strobe. It shows the state before any change made in the same cycle.

Top module: `rtc_secs_top`

## Requirements
- R1: After reset the count is 0x5BFC8900 and the enable bit is 0.
- R2: Each cycle with tick_i high and no accepted count write adds one to the count. 0xFFFFFFFF wraps to 0x00000000.
- R3: A read strobe at address 0 returns count bits 15:0, and at address 1 returns bits 31:16. rdata_o holds the value the cycle after rd_en_i, taken from the state before that cycle's updates.
- R4: A write to address 2 stores wdata_i bit 0 as the enable bit and ignores bits 15:1. A read of address 2 returns the enable bit in bit 0, with bits 15:1 zero.
- R5: With the enable bit at 1, a write to address 0 replaces count bits 15:0, leaves bits 31:16 unchanged and leaves the enable bit at 1.
- R6: With the enable bit at 1, a write to address 1 replaces count bits 31:16, leaves bits 15:0 unchanged and clears the enable bit to 0.
- R7: With the enable bit at 0, writes to addresses 0 and 1 leave the count and the enable bit unchanged. A tick in the same cycle still advances the count.
- R8: When an accepted write to address 0 or 1 coincides with a tick, the count takes the written half and is not incremented.
- R9: A read of address 3 returns zero, and a write to address 3 changes neither the count nor the enable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second strobe, one cycle wide |
| addr_i | input | 2 | Register address: 0 low half, 1 high half, 2 enable, 3 unmapped |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid the cycle after rd_en_i |

## Verification
Some rules are checked by assertions on every cycle:
- a tick with no write advances the count by one;
- an accepted low-half write loads only the low half;
- a high-half write always leaves the window closed;
- a blocked write with no tick leaves the count stable;
- an unmapped read returns zero.

Other behaviour can only be shown by the bench's scenarios: the reset value, the wrap from all ones to zero, the full enable, low, high sequence, the masking of the enable write data, and the tick lost on a collision with a write.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_LO  = 2'd0;
  localparam logic [ADDR_W-1:0] A_HI  = 2'd1;
  localparam logic [ADDR_W-1:0] A_WEN = 2'd2;

  typedef struct packed {
    logic ld_lo;
    logic ld_hi;
    logic ld_wen;
  } rtc_wr_t;
endpackage

// File: rtl/rtc_decode.sv
module rtc_decode
  import rtc_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              wen_q_i,
  output rtc_wr_t           wr_o
);
  // count loads are qualified by the write window here
  always_comb begin
    wr_o.ld_lo  = wr_en_i && wen_q_i && (addr_i == A_LO);
    wr_o.ld_hi  = wr_en_i && wen_q_i && (addr_i == A_HI);
    wr_o.ld_wen = wr_en_i && (addr_i == A_WEN);
  end
endmodule

// File: rtl/rtc_wen_latch.sv
module rtc_wen_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ld_wen_i,
  input  logic wbit_i,
  input  logic ld_hi_i,
  output logic wen_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       wen_q_o <= 1'b0;
    else if (ld_wen_i) wen_q_o <= wbit_i;
    else if (ld_hi_i)  wen_q_o <= 1'b0;
  end

  AST_WEN_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_hi_i |=> !wen_q_o); // R6
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int unsigned CNT_W = 32,
  parameter logic [CNT_W-1:0] RST_VAL = 32'h5BFC_8900,
  localparam int unsigned HALF_W = CNT_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ld_lo_i,
  input  logic              ld_hi_i,
  input  logic [HALF_W-1:0] data_i,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [CNT_W-1:0] cnt_d;

  // host load beats tick
  always_comb begin
    cnt_d = cnt_o;
    if (ld_lo_i)      cnt_d[HALF_W-1:0]     = data_i;
    else if (ld_hi_i) cnt_d[CNT_W-1:HALF_W] = data_i;
    else if (tick_i)  cnt_d = cnt_o + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= RST_VAL;
    else         cnt_o <= cnt_d;
  end

  AST_TICK_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !ld_lo_i && !ld_hi_i) |=> cnt_o == $past(cnt_o) + 1'b1); // R2
  AST_LO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_lo_i |=> (cnt_o[HALF_W-1:0] == $past(data_i)) &&
                (cnt_o[CNT_W-1:HALF_W] == $past(cnt_o[CNT_W-1:HALF_W]))); // R5
  AST_HI_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_hi_i |=> (cnt_o[CNT_W-1:HALF_W] == $past(data_i)) &&
                (cnt_o[HALF_W-1:0] == $past(cnt_o[HALF_W-1:0]))); // R6
endmodule

// File: rtl/rtc_secs_top.sv
module rtc_secs_top
  import rtc_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter logic [CNT_W-1:0] RST_VAL = 32'h5BFC_8900,
  localparam int unsigned HALF_W = CNT_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [HALF_W-1:0] rdata_o
);
  rtc_wr_t          wr;
  logic             wen_q;
  logic [CNT_W-1:0] cnt;
  logic [HALF_W-1:0] rd_mux;

  rtc_decode u_dec (
    .addr_i  (addr_i),
    .wr_en_i (wr_en_i),
    .wen_q_i (wen_q),
    .wr_o    (wr)
  );

  rtc_wen_latch u_wen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_wen_i (wr.ld_wen),
    .wbit_i   (wdata_i[0]),
    .ld_hi_i  (wr.ld_hi),
    .wen_q_o  (wen_q)
  );

  rtc_counter #(.CNT_W(CNT_W), .RST_VAL(RST_VAL)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .ld_lo_i (wr.ld_lo),
    .ld_hi_i (wr.ld_hi),
    .data_i  (wdata_i),
    .cnt_o   (cnt)
  );

  always_comb begin
    unique case (addr_i)
      A_LO:    rd_mux = cnt[HALF_W-1:0];
      A_HI:    rd_mux = cnt[CNT_W-1:HALF_W];
      A_WEN:   rd_mux = {{(HALF_W-1){1'b0}}, wen_q};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  AST_LOCKED_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wen_q && wr_en_i && !tick_i && (addr_i == A_LO || addr_i == A_HI))
      |=> $stable(cnt)); // R7
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 2'd3) |=> rdata_o == '0); // R9
  AST_LOAD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr.ld_lo, wr.ld_hi, wr.ld_wen})); // R5
endmodule

// File: tb/tb_rtc_secs_top.sv
module tb_rtc_secs_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] got;

  always #5 clk = ~clk;

  rtc_secs_top dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // one bus cycle: drive after negedge, release at next negedge
  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d, input logic tk);
    addr = a; wdata = d; wr_en = 1'b1; tick = tk;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic pulse_tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    bus_rd(2'd0, got); check("R1 lo", got, 16'h8900);
    bus_rd(2'd1, got); check("R1 hi", got, 16'h5BFC);
    bus_rd(2'd2, got); check("R1 wen", got, 16'h0000);
  endtask

  task automatic t_locked;
    bus_wr(2'd0, 16'h1111, 1'b0);
    bus_wr(2'd1, 16'h2222, 1'b0);
    bus_rd(2'd0, got); check("R7 lo", got, 16'h8900);
    bus_rd(2'd1, got); check("R7 hi", got, 16'h5BFC);
    bus_wr(2'd0, 16'h3333, 1'b1);
    bus_rd(2'd0, got); check("R7 tick", got, 16'h8901);
  endtask

  task automatic t_tick;
    pulse_tick(3);
    bus_rd(2'd0, got); check("R2 inc", got, 16'h8904);
    // read coincident with tick sees prior value
    addr = 2'd0; rd_en = 1'b1; tick = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; tick = 1'b0;
    check("R3 pre", rdata, 16'h8904);
    bus_rd(2'd0, got); check("R3 post", got, 16'h8905);
  endtask

  task automatic t_wen;
    bus_wr(2'd2, 16'hFFFE, 1'b0);
    bus_rd(2'd2, got); check("R4 mask", got, 16'h0000);
    bus_wr(2'd2, 16'h0003, 1'b0);
    bus_rd(2'd2, got); check("R4 set", got, 16'h0001);
  endtask

  task automatic t_load;
    bus_wr(2'd0, 16'h1234, 1'b0);
    bus_rd(2'd0, got); check("R5 lo", got, 16'h1234);
    bus_rd(2'd1, got); check("R5 hi", got, 16'h5BFC);
    bus_rd(2'd2, got); check("R5 wen", got, 16'h0001);
    bus_wr(2'd1, 16'hABCD, 1'b0);
    bus_rd(2'd1, got); check("R6 hi", got, 16'hABCD);
    bus_rd(2'd0, got); check("R6 lo", got, 16'h1234);
    bus_rd(2'd2, got); check("R6 wen", got, 16'h0000);
    bus_wr(2'd1, 16'h0BAD, 1'b0);
    bus_rd(2'd1, got); check("R7 closed", got, 16'hABCD);
  endtask

  task automatic t_wrap;
    bus_wr(2'd2, 16'h0001, 1'b0);
    bus_wr(2'd0, 16'hFFFF, 1'b0);
    bus_wr(2'd1, 16'hFFFF, 1'b0);
    pulse_tick(1);
    bus_rd(2'd0, got); check("R2 wrap lo", got, 16'h0000);
    bus_rd(2'd1, got); check("R2 wrap hi", got, 16'h0000);
  endtask

  task automatic t_collide;
    bus_wr(2'd2, 16'h0001, 1'b0);
    bus_wr(2'd0, 16'h0010, 1'b1);
    bus_rd(2'd0, got); check("R8 lo", got, 16'h0010);
    bus_wr(2'd1, 16'h0020, 1'b1);
    bus_rd(2'd1, got); check("R8 hi", got, 16'h0020);
    bus_rd(2'd0, got); check("R8 lo kept", got, 16'h0010);
  endtask

  task automatic t_unmapped;
    bus_rd(2'd3, got); check("R9 rd", got, 16'h0000);
    bus_wr(2'd3, 16'hFFFF, 1'b0);
    bus_rd(2'd0, got); check("R9 lo", got, 16'h0010);
    bus_rd(2'd1, got); check("R9 hi", got, 16'h0020);
    bus_rd(2'd2, got); check("R9 wen", got, 16'h0000);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_locked;
    t_tick;
    t_wen;
    t_load;
    t_wrap;
    t_collide;
    t_unmapped;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule